// File: doc/BRIEF.md
# Prioritized Shared-Bus Request Encoder

This block connects four internal bus requesters (a video shift-register transfer unit, a DRAM refresh engine, a host access port and the CPU) to an external arbiter on a shared local-memory bus. It ranks the pending requests and shows the winner's urgency class on a two-bit request/status code. The same code also reports when the current bus owner is on the last cycle of its access. It samples an active-low grant and passes ownership to exactly one requester through one-hot ownership flags.

Refresh urgency comes from an internal saturating count of owed refresh cycles. A periodic tick adds one owed cycle. A completed refresh access pays one back. When the count reaches a threshold, refresh moves from the low class to the high class. The owning requester drives `xfer_last` on the final cycle of its access.

Top module: `bus_req_encoder`

## Requirements
- R1: After reset `req_code` is 2'b11, `owns` is all zero and the owed-refresh count is zero.
- R2: With no owner and no pending source, `req_code` is 2'b11 (nothing pending).
- R3: With no owner, a pending video transfer or a pending host access drives `req_code` to 2'b00 (high class).
- R4: The refresh engine is pending when the owed count is nonzero. It is high class (2'b00) when the count is at least URGENT_AT (default 12) and low class (2'b10) below that.
- R5: With no owner, a pending CPU access alone drives `req_code` to 2'b10 (low class).
- R6: Any high-class source wins over any low-class source. Within the high class the order is video, refresh, host. Within the low class, refresh wins over CPU. `owns` bit positions are video 0, refresh 1, host 2, CPU 3.
- R7: Ownership is granted only on a clock edge where no one owns the bus, a source is selected and `grant_n` is sampled low. The selected source's `owns` bit then rises after that edge, and at most one bit is ever set.
- R8: While a source owns the bus and `xfer_last` is high, `req_code` is 2'b01 (termination). Ownership ends at that edge.
- R9: If `grant_n` is sampled high while a source owns the bus, ownership ends at that edge.
- R10: While a source owns the bus and `xfer_last` is low, `req_code` shows the class the owner was granted in (2'b00 or 2'b10).
- R11: The owed-refresh count saturates at 2**CNT_W-1 and at zero. A tick and a completed refresh at the same edge leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_req | input | 1 | Video shift-register transfer pending |
| host_req | input | 1 | Host access pending |
| cpu_req | input | 1 | CPU access pending |
| refresh_tick | input | 1 | One refresh cycle becomes owed |
| grant_n | input | 1 | Active-low bus grant from the external arbiter |
| xfer_last | input | 1 | Current owner is on its final access cycle |
| req_code | output | 2 | 00 high, 01 termination, 10 low, 11 none |
| owns | output | 4 | One-hot ownership: video, refresh, host, CPU |

## Verification
The hardest states to reach are the refresh count at its ceiling and the edge where a tick and a completed refresh arrive together. The count is visible only through the class of the refresh request. The stimulus therefore sends more ticks than the counter can hold. It then pays the debt back one granted refresh access at a time. The class is expected to drop from high to low at exactly the access that takes the count below the threshold. One of those accesses carries a simultaneous tick, which moves the expected crossing point by one access.

// File: rtl/busreq_pkg.sv
package busreq_pkg;
   typedef enum logic [1:0] {
      CODE_HIGH = 2'b00,
      CODE_TERM = 2'b01,
      CODE_LOW  = 2'b10,
      CODE_IDLE = 2'b11
   } bus_code_e;

   localparam int NUM_SRC  = 4;
   localparam int SRC_W    = $clog2(NUM_SRC);
   localparam int SRC_VID  = 0;
   localparam int SRC_RFSH = 1;
   localparam int SRC_HOST = 2;
   localparam int SRC_CPU  = 3;
endpackage

// File: rtl/busreq_rfsh_cnt.sv
module busreq_rfsh_cnt #(
   parameter int CNT_W     = 5,
   parameter int URGENT_AT = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             done,
   output logic [CNT_W-1:0] cnt,
   output logic             pending,
   output logic             urgent
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] THRESH  = CNT_W'(URGENT_AT);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("busreq_rfsh_cnt: CNT_W must be at least 2");
      end
      if (URGENT_AT < 1 || URGENT_AT > (2**CNT_W) - 1) begin : g_bad_thresh
         $error("busreq_rfsh_cnt: URGENT_AT outside counter range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick && !done) begin
         if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end else if (done && !tick) begin
         if (cnt != '0) cnt <= cnt - 1'b1;
      end
   end

   assign pending = (cnt != '0);
   assign urgent  = (cnt >= THRESH);
endmodule

// File: rtl/busreq_select.sv
module busreq_select
   import busreq_pkg::*;
(
   input  logic             vid_req,
   input  logic             rfsh_pending,
   input  logic             rfsh_urgent,
   input  logic             host_req,
   input  logic             cpu_req,
   output logic             sel_vld,
   output logic [SRC_W-1:0] sel_idx,
   output logic             sel_high
);
   logic [NUM_SRC-1:0] hi_vec;
   logic [NUM_SRC-1:0] lo_vec;
   logic [SRC_W-1:0]   hi_idx;
   logic [SRC_W-1:0]   lo_idx;

   always_comb begin
      hi_vec           = '0;
      lo_vec           = '0;
      hi_vec[SRC_VID]  = vid_req;
      hi_vec[SRC_RFSH] = rfsh_pending && rfsh_urgent;
      hi_vec[SRC_HOST] = host_req;
      lo_vec[SRC_RFSH] = rfsh_pending && !rfsh_urgent;
      lo_vec[SRC_CPU]  = cpu_req;
   end

   // lowest index wins inside each class
   always_comb begin
      hi_idx = '0;
      lo_idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (hi_vec[i]) hi_idx = SRC_W'(i);
         if (lo_vec[i]) lo_idx = SRC_W'(i);
      end
   end

   assign sel_high = |hi_vec;
   assign sel_vld  = sel_high || (|lo_vec);
   assign sel_idx  = sel_high ? hi_idx : lo_idx;
endmodule

// File: rtl/busreq_owner.sv
module busreq_owner
   import busreq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               grant_n,
   input  logic               xfer_last,
   input  logic               sel_vld,
   input  logic [SRC_W-1:0]   sel_idx,
   input  logic               sel_high,
   output logic               own_vld,
   output logic               own_high,
   output logic [NUM_SRC-1:0] owns,
   output logic               rfsh_done
);
   logic [SRC_W-1:0] own_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_vld  <= 1'b0;
         own_idx  <= '0;
         own_high <= 1'b0;
      end else if (own_vld) begin
         if (xfer_last || grant_n) own_vld <= 1'b0;
      end else if (sel_vld && !grant_n) begin
         own_vld  <= 1'b1;
         own_idx  <= sel_idx;
         own_high <= sel_high;
      end
   end

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_own
         assign owns[s] = own_vld && (own_idx == SRC_W'(s));
      end
   endgenerate

   assign rfsh_done = owns[SRC_RFSH] && xfer_last;
endmodule

// File: rtl/bus_req_encoder.sv
module bus_req_encoder
   import busreq_pkg::*;
#(
   parameter int CNT_W     = 5,
   parameter int URGENT_AT = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vid_req,
   input  logic               host_req,
   input  logic               cpu_req,
   input  logic               refresh_tick,
   input  logic               grant_n,
   input  logic               xfer_last,
   output logic [1:0]         req_code,
   output logic [NUM_SRC-1:0] owns
);
   logic [CNT_W-1:0] rfsh_cnt;
   logic             rfsh_pending;
   logic             rfsh_urgent;
   logic             rfsh_done;
   logic             sel_vld;
   logic [SRC_W-1:0] sel_idx;
   logic             sel_high;
   logic             own_vld;
   logic             own_high;
   bus_code_e        code;

   busreq_rfsh_cnt #(.CNT_W(CNT_W), .URGENT_AT(URGENT_AT)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (refresh_tick),
      .done    (rfsh_done),
      .cnt     (rfsh_cnt),
      .pending (rfsh_pending),
      .urgent  (rfsh_urgent)
   );

   busreq_select sel_i (
      .vid_req      (vid_req),
      .rfsh_pending (rfsh_pending),
      .rfsh_urgent  (rfsh_urgent),
      .host_req     (host_req),
      .cpu_req      (cpu_req),
      .sel_vld      (sel_vld),
      .sel_idx      (sel_idx),
      .sel_high     (sel_high)
   );

   busreq_owner own_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant_n   (grant_n),
      .xfer_last (xfer_last),
      .sel_vld   (sel_vld),
      .sel_idx   (sel_idx),
      .sel_high  (sel_high),
      .own_vld   (own_vld),
      .own_high  (own_high),
      .owns      (owns),
      .rfsh_done (rfsh_done)
   );

   always_comb begin
      if (own_vld) begin
         if (xfer_last)     code = CODE_TERM;
         else if (own_high) code = CODE_HIGH;
         else               code = CODE_LOW;
      end else if (sel_vld) begin
         code = sel_high ? CODE_HIGH : CODE_LOW;
      end else begin
         code = CODE_IDLE;
      end
   end

   assign req_code = code;
endmodule

// File: rtl/busreq_chk.sv
module busreq_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vid_req,
   input logic             host_req,
   input logic             cpu_req,
   input logic             refresh_tick,
   input logic             grant_n,
   input logic [1:0]       req_code,
   input logic [3:0]       owns,
   input logic [CNT_W-1:0] cnt,
   input logic             done
);
   AST_OWN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owns)); // R7
   AST_GRANT_SAMPLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|owns) |-> $past(!grant_n)); // R7
   AST_TERM_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_code == 2'b01) |=> (owns == 4'b0000)); // R8
   AST_DROP_ON_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      ((|owns) && grant_n) |=> (owns == 4'b0000)); // R9
   AST_VID_HIGH_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      ((owns == 4'b0000) && vid_req) |-> (req_code == 2'b00)); // R6
   AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      ((owns == 4'b0000) && !vid_req && !host_req && !cpu_req && (cnt == '0))
      |-> (req_code == 2'b11)); // R2
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((&cnt) && refresh_tick && !done) |=> (&cnt)); // R11
endmodule

bind bus_req_encoder busreq_chk #(.CNT_W(CNT_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .vid_req      (vid_req),
   .host_req     (host_req),
   .cpu_req      (cpu_req),
   .refresh_tick (refresh_tick),
   .grant_n      (grant_n),
   .req_code     (req_code),
   .owns         (owns),
   .cnt          (rfsh_cnt),
   .done         (rfsh_done)
);

// File: tb/bus_req_encoder_tb_top.sv
module bus_req_encoder_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vid_req = 1'b0, host_req = 1'b0, cpu_req = 1'b0;
   logic       refresh_tick = 1'b0, grant_n = 1'b1, xfer_last = 1'b0;
   logic [1:0] req_code;
   logic [3:0] owns;
   int         checks = 0;
   int         failures = 0;

   always #10 clk = ~clk;

   bus_req_encoder dut_i (
      .clk(clk), .rst_n(rst_n), .vid_req(vid_req), .host_req(host_req),
      .cpu_req(cpu_req), .refresh_tick(refresh_tick), .grant_n(grant_n),
      .xfer_last(xfer_last), .req_code(req_code), .owns(owns)
   );

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   // one full granted access; inputs driven at negedge
   task automatic access(input string req, input logic [3:0] exp_own, input logic tick_at_end);
      grant_n = 1'b0;
      cyc();
      chk(req, owns, exp_own);
      xfer_last = 1'b1;
      refresh_tick = tick_at_end;
      #1 chk({req, " term"}, {2'b00, req_code}, 4'b0001);
      cyc();
      xfer_last = 1'b0;
      refresh_tick = 1'b0;
      grant_n = 1'b1;
      chk({req, " released"}, owns, 4'b0000);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         refresh_tick = 1'b1;
         cyc();
         refresh_tick = 1'b0;
      end
   endtask

   task automatic t_reset();
      #1 chk("R1 code", {2'b00, req_code}, 4'b0011);
      chk("R1 owns", owns, 4'b0000);
      cyc(); cyc();
      rst_n = 1'b1;
      cyc();
      chk("R1 code after", {2'b00, req_code}, 4'b0011);
   endtask

   task automatic t_single();
      vid_req = 1'b1;  #1 chk("R3 video", {2'b00, req_code}, 4'b0000);
      vid_req = 1'b0;  host_req = 1'b1;
      #1 chk("R3 host", {2'b00, req_code}, 4'b0000);
      host_req = 1'b0; cpu_req = 1'b1;
      #1 chk("R5 cpu", {2'b00, req_code}, 4'b0010);
      cpu_req = 1'b0;
      #1 chk("R2 none", {2'b00, req_code}, 4'b0011);
      cyc();
   endtask

   task automatic t_priority();
      vid_req = 1'b1; host_req = 1'b1; cpu_req = 1'b1;
      #1 chk("R6 mixed code", {2'b00, req_code}, 4'b0000);
      access("R6 video wins", 4'b0001, 1'b0);
      vid_req = 1'b0;
      #1 chk("R6 host over cpu code", {2'b00, req_code}, 4'b0000);
      access("R6 host wins", 4'b0100, 1'b0);
      host_req = 1'b0; cpu_req = 1'b0;
      cyc();
   endtask

   task automatic t_grant();
      cpu_req = 1'b1;
      cyc();
      chk("R7 no grant while grant_n high", owns, 4'b0000);
      grant_n = 1'b0;
      cyc();
      chk("R7 cpu granted", owns, 4'b1000);
      #1 chk("R10 owner class low", {2'b00, req_code}, 4'b0010);
      cyc();
      chk("R10 still owned", owns, 4'b1000);
      xfer_last = 1'b1;
      #1 chk("R8 termination code", {2'b00, req_code}, 4'b0001);
      cyc();
      xfer_last = 1'b0; grant_n = 1'b1;
      chk("R8 released", owns, 4'b0000);
      cpu_req = 1'b0; host_req = 1'b1; grant_n = 1'b0;
      cyc();
      chk("R9 host granted", owns, 4'b0100);
      #1 chk("R10 owner class high", {2'b00, req_code}, 4'b0000);
      grant_n = 1'b1;
      cyc();
      chk("R9 dropped on grant_n high", owns, 4'b0000);
      host_req = 1'b0;
      cyc();
   endtask

   task automatic t_refresh();
      ticks(11);
      #1 chk("R4 count 11 low class", {2'b00, req_code}, 4'b0010);
      ticks(1);
      #1 chk("R4 count 12 high class", {2'b00, req_code}, 4'b0000);
      host_req = 1'b1;
      access("R6 urgent refresh over host", 4'b0010, 1'b1);
      host_req = 1'b0;
      ticks(28);  // count 40 requested, saturates at 31
      for (int i = 0; i < 19; i++) access("R11 refresh drain", 4'b0010, 1'b0);
      #1 chk("R11 saturated then 19 paid -> high", {2'b00, req_code}, 4'b0000);
      access("R11 tick with done", 4'b0010, 1'b1);
      #1 chk("R11 tick+done unchanged", {2'b00, req_code}, 4'b0000);
      access("R11 drain below threshold", 4'b0010, 1'b0);
      #1 chk("R11 count 11 low class", {2'b00, req_code}, 4'b0010);
      cpu_req = 1'b1;
      access("R6 low refresh over cpu", 4'b0010, 1'b0);
      cpu_req = 1'b0;
      for (int i = 0; i < 10; i++) access("R4 drain", 4'b0010, 1'b0);
      #1 chk("R4 count zero no request", {2'b00, req_code}, 4'b0011);
   endtask

   initial begin
      #3000000;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_single();
      t_priority();
      t_grant();
      t_refresh();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule